// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit gathers the event sources of a serial port (transmitter, receiver, the two FIFOs, line errors, break completion, a bus error on an illegal empty-FIFO read, and the clear-to-send modem input) into a 14-bit sticky status register. A 14-bit enable register uses the same bit positions. The unit drives a single active-high level interrupt whenever some status bit is set and its enable bit is also set.

Neighbouring logic presents events on `evt_i` as one-cycle pulses or as levels. Every cycle in which a bit is high sets the matching status bit. Software acknowledges events by writing ones to the status bits it has serviced. The unit also brings the asynchronous clear-to-send pin into the clock domain through a two-flop synchronizer. It presents the resulting level and turns every change of that level into a status event of its own.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset, `stat_o`, `en_o`, `irq_o` and `cts_level_o` are all 0, provided `cts_i` is held at 0 during reset.
- R2: A high `evt_i[k]` in a cycle sets `stat_o[k]` at the next clock edge, whatever the enable register holds. The bit then stays set without further events until it is cleared. Bit map: 0 transmit data empty, 1 receive data full, 2 transmit FIFO nearly empty, 3 transmit FIFO empty, 4 receive FIFO nearly full, 5 receive FIFO full, 6 transmit underrun, 7 receive overrun, 8 parity error, 9 framing error, 10 clear-to-send change, 11 receive timeout, 12 break finished, 13 bus error response.
- R3: A write with `wr_en`=1 and `wr_sel`=1 (status target) clears, at the next edge, every status bit whose `wr_data` bit is 1 and leaves every bit whose `wr_data` bit is 0 unchanged.
- R4: When a status bit receives a set event and a clear in the same cycle, the bit is 1 after the edge.
- R5: A write with `wr_en`=1 and `wr_sel`=0 (enable target) loads `wr_data` into `en_o` at the next edge. Without such a write, `en_o` holds its value.
- R6: `irq_o` is 1 exactly when at least one bit position has both `stat_o` and `en_o` set. It follows the registers in the same cycle.
- R7: `cts_level_o` equals the value `cts_i` had two clock edges earlier.
- R8: Every change of `cts_level_o`, rising or falling, sets `stat_o[10]` at the following clock edge.
- R9: `evt_i[10]` has no effect. Status bit 10 is set only by a clear-to-send change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 14 | Event sources, one per status bit (bit 10 unused) |
| cts_i | input | 1 | Asynchronous clear-to-send pin |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enable register, 1 status clear |
| wr_data | input | 14 | Write data or clear mask |
| stat_o | output | 14 | Status register |
| en_o | output | 14 | Enable register |
| irq_o | output | 1 | Level interrupt, active high |
| cts_level_o | output | 1 | Synchronized clear-to-send level |

## Verification
The collision that matters is a source event and a write-one-to-clear of the same status bit in one cycle. It is provoked by driving `evt_i[0]` high in the same cycle as a status write whose mask covers bit 0, and it is judged by requiring bit 0 still set afterwards. A second collision is a clear-to-send change whose flag lands while software is clearing bit 10; it arises inside a pseudo-random stream where the bench model applies the same set-wins rule. Every cycle of that stream compares status, enable, interrupt and synchronized level against the model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned NSRC = 14;

    typedef enum logic [3:0] {
        SRC_TXD_EMPTY   = 4'd0,
        SRC_RXD_FULL    = 4'd1,
        SRC_TXF_LOW     = 4'd2,
        SRC_TXF_EMPTY   = 4'd3,
        SRC_RXF_HIGH    = 4'd4,
        SRC_RXF_FULL    = 4'd5,
        SRC_TX_UNDERRUN = 4'd6,
        SRC_RX_OVERRUN  = 4'd7,
        SRC_PARITY      = 4'd8,
        SRC_FRAMING     = 4'd9,
        SRC_CTS_CHANGE  = 4'd10,
        SRC_RX_TIMEOUT  = 4'd11,
        SRC_BREAK_DONE  = 4'd12,
        SRC_BUS_ERROR   = 4'd13
    } src_e;

    localparam int unsigned CTS_IDX = int'(SRC_CTS_CHANGE);

    typedef logic [NSRC-1:0] srcvec_t;

endpackage

// File: rtl/cts_sync_edge.sv
module cts_sync_edge #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_i,
    output logic level_o,
    output logic tgl_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } cts_state_t;

    cts_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[LAST-1:0], cts_i};
        st_d.last = st_q.sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= {STAGES{RST_LEVEL}};
            st_q.last <= RST_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.sync[LAST];
    assign tgl_o   = st_q.sync[LAST] ^ st_q.last;

    // R7: the synchronized level reflects the pin value seen two edges before
    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.sync[0]) == level_o || $past(!rst_n));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned W       = uart_irq_pkg::NSRC,
    parameter int unsigned CTS_IDX = uart_irq_pkg::CTS_IDX
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         cts_tgl_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } bank_state_t;

    bank_state_t  st_d, st_q;
    logic [W-1:0] set_vec;

    for (genvar k = 0; k < W; k++) begin : g_src
        if (k == CTS_IDX) begin : g_cts
            assign set_vec[k] = cts_tgl_i;

            // R8: a level change always lands in the status bit
            assert_cts_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
                cts_tgl_i |=> st_q.stat[k]);

            // R9: the generic event input at this position is inert
            assert_evt_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_i[k] && !cts_tgl_i && !st_q.stat[k]) |=> !st_q.stat[k]);
        end else begin : g_evt
            assign set_vec[k] = evt_i[k];

            // R2: an event sets its bit regardless of enables
            assert_evt_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[k] |=> st_q.stat[k]);
        end

        // R4: set and clear together leave the bit set
        assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[k] && clr_i[k]) |=> st_q.stat[k]);

        // R3: a clear without a set empties the bit
        assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_vec[k]) |=> !st_q.stat[k]);

        // R3: without a clear a set bit is sticky
        assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.stat[k] && !clr_i[k]) |=> st_q.stat[k]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr_i) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int unsigned W = uart_irq_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.en = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    // R5: a load takes the written mask
    assert_en_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (en_o == $past(data_i)));

    // R5: no load, no change
    assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(en_o));

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
    parameter int unsigned NSRC       = uart_irq_pkg::NSRC,
    parameter int unsigned CTS_IDX    = uart_irq_pkg::CTS_IDX,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            cts_i,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [NSRC-1:0] wr_data,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] en_o,
    output logic            irq_o,
    output logic            cts_level_o
);
    logic            cts_tgl;
    logic            en_ld;
    logic [NSRC-1:0] clr_mask;

    assign en_ld    = wr_en && !wr_sel;
    assign clr_mask = (wr_en && wr_sel) ? wr_data : '0;

    cts_sync_edge #(
        .STAGES    (SYNC_DEPTH),
        .RST_LEVEL (1'b0)
    ) u_cts (
        .clk     (clk),
        .rst_n   (rst_n),
        .cts_i   (cts_i),
        .level_o (cts_level_o),
        .tgl_o   (cts_tgl)
    );

    irq_status_bank #(
        .W       (NSRC),
        .CTS_IDX (CTS_IDX)
    ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .cts_tgl_i (cts_tgl),
        .clr_i     (clr_mask),
        .stat_o    (stat_o)
    );

    irq_enable_reg #(
        .W (NSRC)
    ) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (en_ld),
        .data_i (wr_data),
        .en_o   (en_o)
    );

    assign irq_o = |(stat_o & en_o);

    // R6: disabling every source silences the line on the next cycle
    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && (wr_data == '0)) |=> !irq_o);

    // R6: full enable plus a live event raises the line on the next cycle
    assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && (wr_data == '1) && evt_i[0]) |=> irq_o);

    // R8: a level change at the port is followed by the change flag
    assert_cts_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cts_level_o) |=> stat_o[CTS_IDX]);

endmodule

// File: tb/uart_irq_unit_test.sv
module uart_irq_unit_test;
    localparam int W = 14;
    localparam int WATCHDOG_CYC = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_i = '0;
    logic         cts_i = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] stat_o, en_o;
    logic         irq_o, cts_level_o;

    always #5 clk = ~clk;

    uart_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cts_i(cts_i),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .stat_o(stat_o), .en_o(en_o), .irq_o(irq_o), .cts_level_o(cts_level_o)
    );

    typedef struct {
        int           due;
        string        tag;
        logic [W-1:0] stat;
        logic [W-1:0] en;
        logic         irq;
        logic         lvl;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    // reference state built from the requirements
    logic [W-1:0] m_stat = '0;
    logic [W-1:0] m_en = '0;
    logic         m_c1 = 1'b0, m_lvl = 1'b0, m_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares every expectation when its cycle comes due
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (stat_o !== e.stat || en_o !== e.en || irq_o !== e.irq || cts_level_o !== e.lvl) begin
                n_fail++;
                $display("FAIL %s cyc %0d: actual stat=%h en=%h irq=%b lvl=%b expected stat=%h en=%h irq=%b lvl=%b",
                         e.tag, cyc, stat_o, en_o, irq_o, cts_level_o, e.stat, e.en, e.irq, e.lvl);
            end
        end
    end

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic [W-1:0] e, input logic we, input logic sel,
                        input logic [W-1:0] d, input logic c, input string tag);
        logic [W-1:0] clr;
        logic [W-1:0] setv;
        exp_t x;
        @(negedge clk);
        evt_i = e; wr_en = we; wr_sel = sel; wr_data = d; cts_i = c;
        clr  = (we && sel) ? d : '0;
        setv = e & ~(W'(1) << 10);                 // R9: bit 10 of evt_i is inert
        if (m_lvl != m_prev) setv[10] = 1'b1;      // R8: level change flags bit 10
        m_stat = (m_stat & ~clr) | setv;           // R3/R4: set wins over clear
        if (we && !sel) m_en = d;                  // R5
        m_prev = m_lvl; m_lvl = m_c1; m_c1 = c;    // R7: two-edge delay
        x.due = cyc + 1; x.tag = tag; x.stat = m_stat; x.en = m_en;
        x.irq = |(m_stat & m_en);                  // R6
        x.lvl = m_lvl;
        exp_q.push_back(x);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, '0, cts_i, tag);
    endtask

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(1, "R1");
        // R2: events on bits 0 and 13 with everything disabled; no interrupt
        step(14'h2001, 1'b0, 1'b0, '0, 1'b0, "R2");
        idle(2, "R2 sticky");
        // R5/R6: enable bus error bit -> interrupt rises
        step('0, 1'b1, 1'b0, 14'h2000, 1'b0, "R5 R6");
        idle(1, "R6");
        // R3: clear bit 13 only, bit 0 stays; interrupt falls
        step('0, 1'b1, 1'b1, 14'h2000, 1'b0, "R3");
        idle(1, "R3");
        // R3: writing zeros clears nothing
        step('0, 1'b1, 1'b1, 14'h0000, 1'b0, "R3 zeros");
        // R4: event and clear of bit 0 in the same cycle
        step(14'h0001, 1'b1, 1'b1, 14'h0001, 1'b0, "R4");
        idle(1, "R4");
        step('0, 1'b1, 1'b1, 14'h3fff, 1'b0, "R3 all");
        // R9: evt_i[10] alone leaves status untouched
        step(14'h0400, 1'b0, 1'b0, '0, 1'b0, "R9");
        idle(2, "R9");
        // R7/R8: rising clear-to-send
        step('0, 1'b1, 1'b0, 14'h0400, 1'b1, "R7");
        idle(4, "R7 R8 rise");
        step('0, 1'b1, 1'b1, 14'h0400, 1'b1, "R8 ack");
        // R7/R8: falling clear-to-send
        step('0, 1'b0, 1'b0, '0, 1'b0, "R7");
        idle(4, "R7 R8 fall");
        // R6: disable all
        step('0, 1'b1, 1'b0, 14'h0000, 1'b0, "R6 off");
        // R6: enable all with an event in flight
        step(14'h0001, 1'b1, 1'b0, 14'h3fff, 1'b0, "R6 on");
        idle(1, "R6");
        // R2/R4/R8: pseudo-random mix including collisions
        lf = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[13:0] & {lf[9:0], lf[15:12]}, lf[14], lf[15],
                 {lf[6:0], lf[13:7]}, lf[3], "R2 mix");
        end
        idle(3, "R2 drain");
        @(negedge clk); #2;
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule